// File: doc/BRIEF.md
# Long Multiply-Accumulate Unit

This block is a single-cycle registered integer multiplier with a 32x32 input and a 64-bit result. It serves the execute stage of a processor pipeline. One datapath handles the whole multiply family:
- word multiply and multiply-add;
- signed and unsigned long multiply, with or without a 64-bit accumulator;
- an unsigned long multiply that adds two independent 32-bit addends;
- signed high-word multiply, multiply-add and multiply-subtract, each with optional rounding.

The issuing stage decodes the instruction and fetches the register operands. It also evaluates the condition and presents the result as one condition-pass bit. The unit returns a low word and a high word, with a write enable for each destination. It also returns the next N and Z flags with a flag-write strobe. The incoming C and V flags are carried through untouched.

An operation is issued by raising `inValid` for one cycle. Its result shows on the outputs in the next cycle, marked by `outValid`. The op code is 4 bits wide. For the high-word family, bit 3 is set and bit 2 selects rounding.

Top module: `lmac_unit`

## Requirements
- R1: An issue with a legal op code and `condPass` high yields exactly one cycle of `outValid` on the clock edge after the issue. `wrLo`, `wrHi` and `flagWr` are only ever high together with `outValid`.
- R2: Word ops write only the low destination (`wrLo`=1, `wrHi`=0). Op 0 gives the low 32 bits of srcA*srcB. Op 1 gives the low 32 bits of srcA*srcB+accLo.
- R3: Op codes 2 and 3 zero-extend both operands to 64 bits before multiplying. Op codes 4 and 5 sign-extend both operands. All four return bits 31:0 on `resLo` and bits 63:32 on `resHi`, with both write enables high.
- R4: The long accumulate ops (3 unsigned, 5 signed) add the 64-bit value whose bits 63:32 are `accHi` and whose bits 31:0 are `accLo`.
- R5: Op 6 returns zext(srcA)*zext(srcB)+zext(accHi)+zext(accLo) over 64 bits and never raises `flagWr`.
- R6: High-word ops take `accLo` as bits 63:32 of a 64-bit value whose low bits are zero; op 8 uses zero in its place.
  - Ops 8 and 9 add the signed 64-bit product to this value; op 10 subtracts it.
  - The result is bits 63:32, returned on `resLo` with only `wrLo` set.
  - Codes 12, 13 and 14 are the same ops with rounding, which adds bit 31 of the 64-bit intermediate to the result.
- R7: For ops 0 and 1 with `setFlags` high, N is bit 31 of the result and Z is set when the 32-bit result is zero.
- R8: For ops 2 to 5 with `setFlags` high, N is bit 63 of the result and Z is set only when all 64 bits are zero.
- R9: Without a flag update (`setFlags` low, or op 6 or a high-word op), `flagWr` is low and `nOut`/`zOut` repeat the issued `nIn`/`zIn`. `cOut`/`vOut` always repeat the issued `cIn`/`vIn`.
- R10: With `condPass` low an issue produces no `outValid`, no write enable and no `flagWr`.
- R11: The unused op codes 7, 11 and 15 produce no `outValid`.
- R12: While `rstN` is low every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Issue strobe |
| condPass | input | 1 | Condition result of the issuing stage |
| opSel | input | 4 | Operation code |
| setFlags | input | 1 | Request N/Z update |
| srcA | input | 32 | First multiplicand |
| srcB | input | 32 | Second multiplicand |
| accLo | input | 32 | Word accumulator / low half of long accumulator |
| accHi | input | 32 | High half of long accumulator / second addend |
| nIn | input | 1 | Current N flag |
| zIn | input | 1 | Current Z flag |
| cIn | input | 1 | Current C flag |
| vIn | input | 1 | Current V flag |
| outValid | output | 1 | Result valid |
| resLo | output | 32 | Low result word |
| resHi | output | 32 | High result word |
| wrLo | output | 1 | Write enable for the low destination |
| wrHi | output | 1 | Write enable for the high destination |
| flagWr | output | 1 | Flag write strobe |
| nOut | output | 1 | Next N flag |
| zOut | output | 1 | Next Z flag |
| cOut | output | 1 | Next C flag |
| vOut | output | 1 | Next V flag |

## Verification
The properties assume that `inValid` is a single-cycle pulse per operation, with the op code, operands and flag inputs stable while it is high. They also assume that `opSel` is driven to a known value whenever `inValid` is high. The stimulus meets this by issuing every operation from one task at the falling edge and holding `inValid` low between operations.

The stimulus deliberately includes the unused codes and issues with `condPass` low. These cases exercise the suppression properties on legal input shapes.

// File: rtl/lmac_pkg.sv
package lmac_pkg;

  typedef enum logic [3:0] {
    OP_MUL     = 4'd0,
    OP_MULADD  = 4'd1,
    OP_UMUL    = 4'd2,
    OP_UMAC    = 4'd3,
    OP_SMUL    = 4'd4,
    OP_SMAC    = 4'd5,
    OP_UDADD   = 4'd6,
    OP_HMUL    = 4'd8,
    OP_HMAC    = 4'd9,
    OP_HMSB    = 4'd10,
    OP_HMUL_R  = 4'd12,
    OP_HMAC_R  = 4'd13,
    OP_HMSB_R  = 4'd14
  } opSel_e;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_WORD,
    ACC_PAIR,
    ACC_DUAL,
    ACC_TOP
  } accMode_e;

  typedef struct packed {
    logic     issue;
    logic     signedOp;
    accMode_e accMode;
    logic     negate;
    logic     highWord;
    logic     roundEn;
    logic     wideFlags;
    logic     wrLo;
    logic     wrHi;
    logic     flagWr;
  } lmacCtrl_t;

endpackage

// File: rtl/lmac_ctrl.sv
module lmac_ctrl
  import lmac_pkg::*;
(
  input  logic       inValid,
  input  logic       condPass,
  input  logic [3:0] opSel,
  input  logic       setFlags,
  output lmacCtrl_t  ctrl
);

  logic legal;
  logic flagable;

  always_comb begin
    ctrl          = '0;
    ctrl.accMode  = ACC_NONE;
    legal         = 1'b1;
    flagable      = 1'b0;
    case (opSel)
      OP_MUL:    begin ctrl.wrLo = 1'b1; flagable = 1'b1; end
      OP_MULADD: begin ctrl.wrLo = 1'b1; flagable = 1'b1; ctrl.accMode = ACC_WORD; end
      OP_UMUL:   begin ctrl.wrLo = 1'b1; ctrl.wrHi = 1'b1; flagable = 1'b1; ctrl.wideFlags = 1'b1; end
      OP_UMAC:   begin ctrl.wrLo = 1'b1; ctrl.wrHi = 1'b1; flagable = 1'b1; ctrl.wideFlags = 1'b1;
                       ctrl.accMode = ACC_PAIR; end
      OP_SMUL:   begin ctrl.wrLo = 1'b1; ctrl.wrHi = 1'b1; flagable = 1'b1; ctrl.wideFlags = 1'b1;
                       ctrl.signedOp = 1'b1; end
      OP_SMAC:   begin ctrl.wrLo = 1'b1; ctrl.wrHi = 1'b1; flagable = 1'b1; ctrl.wideFlags = 1'b1;
                       ctrl.signedOp = 1'b1; ctrl.accMode = ACC_PAIR; end
      OP_UDADD:  begin ctrl.wrLo = 1'b1; ctrl.wrHi = 1'b1; ctrl.accMode = ACC_DUAL; end
      OP_HMUL, OP_HMUL_R,
      OP_HMAC, OP_HMAC_R,
      OP_HMSB, OP_HMSB_R: begin
        ctrl.wrLo     = 1'b1;
        ctrl.signedOp = 1'b1;
        ctrl.highWord = 1'b1;
        ctrl.roundEn  = opSel[2];
        ctrl.negate   = (opSel[1:0] == 2'd2);
        ctrl.accMode  = (opSel[1:0] == 2'd0) ? ACC_NONE : ACC_TOP;
      end
      default:   legal = 1'b0;
    endcase
    ctrl.issue  = inValid & condPass & legal;
    ctrl.wrLo   = ctrl.wrLo & ctrl.issue;
    ctrl.wrHi   = ctrl.wrHi & ctrl.issue;
    ctrl.flagWr = flagable & setFlags & ctrl.issue;
  end

endmodule

// File: rtl/lmac_datapath.sv
module lmac_datapath
  import lmac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  lmacCtrl_t    ctrl,
  input  logic [W-1:0] srcA,
  input  logic [W-1:0] srcB,
  input  logic [W-1:0] accLo,
  input  logic [W-1:0] accHi,
  input  logic         nIn,
  input  logic         zIn,
  input  logic         cIn,
  input  logic         vIn,
  output logic         outValid,
  output logic [W-1:0] resLo,
  output logic [W-1:0] resHi,
  output logic         wrLo,
  output logic         wrHi,
  output logic         flagWr,
  output logic         nOut,
  output logic         zOut,
  output logic         cOut,
  output logic         vOut
);

  localparam int DW = 2 * W;

  logic [DW-1:0] aExt, bExt, prod, accVal, sum;
  logic [W-1:0]  hiWord, loNext, hiNext;
  logic          nNext, zNext;

  always_comb begin
    aExt = {{W{ctrl.signedOp & srcA[W-1]}}, srcA};
    bExt = {{W{ctrl.signedOp & srcB[W-1]}}, srcB};
    prod = aExt * bExt;
    case (ctrl.accMode)
      ACC_WORD: accVal = {{W{1'b0}}, accLo};
      ACC_PAIR: accVal = {accHi, accLo};
      ACC_DUAL: accVal = {{W{1'b0}}, accHi} + {{W{1'b0}}, accLo};
      ACC_TOP:  accVal = {accLo, {W{1'b0}}};
      default:  accVal = '0;
    endcase
    sum    = ctrl.negate ? (accVal - prod) : (accVal + prod);
    hiWord = sum[DW-1:W] + {{(W-1){1'b0}}, ctrl.roundEn & sum[W-1]};
    loNext = ctrl.highWord ? hiWord : sum[W-1:0];
    hiNext = ctrl.wrHi ? sum[DW-1:W] : '0;
    nNext  = ctrl.wideFlags ? sum[DW-1] : sum[W-1];
    zNext  = ctrl.wideFlags ? (sum == '0) : (sum[W-1:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      wrLo     <= 1'b0;
      wrHi     <= 1'b0;
      flagWr   <= 1'b0;
      resLo    <= '0;
      resHi    <= '0;
      nOut     <= 1'b0;
      zOut     <= 1'b0;
      cOut     <= 1'b0;
      vOut     <= 1'b0;
    end else begin
      outValid <= ctrl.issue;
      wrLo     <= ctrl.wrLo;
      wrHi     <= ctrl.wrHi;
      flagWr   <= ctrl.flagWr;
      if (ctrl.issue) begin
        resLo <= loNext;
        resHi <= hiNext;
        nOut  <= ctrl.flagWr ? nNext : nIn;
        zOut  <= ctrl.flagWr ? zNext : zIn;
        cOut  <= cIn;
        vOut  <= vIn;
      end
    end
  end

endmodule

// File: rtl/lmac_unit.sv
module lmac_unit
  import lmac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         condPass,
  input  logic [3:0]   opSel,
  input  logic         setFlags,
  input  logic [W-1:0] srcA,
  input  logic [W-1:0] srcB,
  input  logic [W-1:0] accLo,
  input  logic [W-1:0] accHi,
  input  logic         nIn,
  input  logic         zIn,
  input  logic         cIn,
  input  logic         vIn,
  output logic         outValid,
  output logic [W-1:0] resLo,
  output logic [W-1:0] resHi,
  output logic         wrLo,
  output logic         wrHi,
  output logic         flagWr,
  output logic         nOut,
  output logic         zOut,
  output logic         cOut,
  output logic         vOut
);

  lmacCtrl_t ctrl;

  lmac_ctrl i_ctrl (
    .inValid (inValid),
    .condPass(condPass),
    .opSel   (opSel),
    .setFlags(setFlags),
    .ctrl    (ctrl)
  );

  lmac_datapath #(.W(W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .srcA    (srcA),
    .srcB    (srcB),
    .accLo   (accLo),
    .accHi   (accHi),
    .nIn     (nIn),
    .zIn     (zIn),
    .cIn     (cIn),
    .vIn     (vIn),
    .outValid(outValid),
    .resLo   (resLo),
    .resHi   (resHi),
    .wrLo    (wrLo),
    .wrHi    (wrHi),
    .flagWr  (flagWr),
    .nOut    (nOut),
    .zOut    (zOut),
    .cOut    (cOut),
    .vOut    (vOut)
  );

endmodule

// File: rtl/lmac_chk.sv
module lmac_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         condPass,
  input logic [3:0]   opSel,
  input logic         setFlags,
  input logic [W-1:0] srcA,
  input logic [W-1:0] srcB,
  input logic [W-1:0] accLo,
  input logic [W-1:0] accHi,
  input logic         nIn,
  input logic         zIn,
  input logic         cIn,
  input logic         vIn,
  input logic         outValid,
  input logic [W-1:0] resLo,
  input logic [W-1:0] resHi,
  input logic         wrLo,
  input logic         wrHi,
  input logic         flagWr,
  input logic         nOut,
  input logic         zOut,
  input logic         cOut,
  input logic         vOut
);

  // R1
  strobe_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!wrLo && !wrHi && !flagWr));

  // R10
  cond_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !condPass) |=> (!outValid && !wrLo && !flagWr));

  // R11
  unused_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opSel == 4'd7 || opSel == 4'd11 || opSel == 4'd15)) |=> !outValid);

  // R5
  dual_add_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 4'd6) |=> !flagWr);

  // R6
  high_one_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && condPass && opSel[3]) |=> (!wrHi && !flagWr));

  // R9
  cv_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (cOut == $past(cIn) && vOut == $past(vIn)));

  // R9
  flag_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWr |-> $past(setFlags));

endmodule

bind lmac_unit lmac_chk #(.W(W)) u_lmac_chk (.*);

// File: tb/test_lmac_unit.sv
module test_lmac_unit;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        vld;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        wl, wh, fw, n, z, c, v;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, condPass = 1'b0, setFlags = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] srcA = '0, srcB = '0, accLo = '0, accHi = '0;
  logic        nIn = 1'b0, zIn = 1'b0, cIn = 1'b0, vIn = 1'b0;
  logic        outValid, wrLo, wrHi, flagWr, nOut, zOut, cOut, vOut;
  logic [31:0] resLo, resHi;

  int   checks = 0;
  int   fails  = 0;
  bit   running = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  lmac_unit i_lmac_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .condPass(condPass), .opSel(opSel),
    .setFlags(setFlags), .srcA(srcA), .srcB(srcB), .accLo(accLo), .accHi(accHi),
    .nIn(nIn), .zIn(zIn), .cIn(cIn), .vIn(vIn), .outValid(outValid), .resLo(resLo),
    .resHi(resHi), .wrLo(wrLo), .wrHi(wrHi), .flagWr(flagWr), .nOut(nOut),
    .zOut(zOut), .cOut(cOut), .vOut(vOut)
  );

  function automatic exp_t model(input logic [3:0] op, input logic [31:0] a, b, lo, hi,
                                 input logic sf, cp, n, z, c, v, input string tag);
    exp_t        e;
    logic [63:0] s, sp, t;
    logic [31:0] w;
    e = '{vld: 1'b0, lo: '0, hi: '0, wl: 0, wh: 0, fw: 0, n: n, z: z, c: c, v: v, tag: tag};
    sp = 64'(longint'($signed(a)) * longint'($signed(b)));
    case (op)
      4'd0, 4'd1: begin
        w = a * b;
        if (op == 4'd1) w = w + lo;
        e.lo = w; e.wl = 1; e.vld = 1;
        if (sf) begin e.fw = 1; e.n = w[31]; e.z = (w == 0); end
      end
      4'd2, 4'd3, 4'd4, 4'd5, 4'd6: begin
        if (op == 4'd4 || op == 4'd5) s = sp;
        else s = {32'd0, a} * {32'd0, b};
        if (op == 4'd3 || op == 4'd5) s = s + {hi, lo};
        if (op == 4'd6) s = s + {32'd0, hi} + {32'd0, lo};
        e.lo = s[31:0]; e.hi = s[63:32]; e.wl = 1; e.wh = 1; e.vld = 1;
        if (sf && op != 4'd6) begin e.fw = 1; e.n = s[63]; e.z = (s == 0); end
      end
      4'd8, 4'd9, 4'd10, 4'd12, 4'd13, 4'd14: begin
        t = (op[1:0] == 2'd0) ? 64'd0 : {lo, 32'd0};
        t = (op[1:0] == 2'd2) ? t - sp : t + sp;
        e.lo = t[63:32] + (op[2] ? {31'd0, t[31]} : 32'd0);
        e.wl = 1; e.vld = 1;
      end
      default: e.vld = 0;
    endcase
    if (!cp) begin e.vld = 0; e.wl = 0; e.wh = 0; e.fw = 0; end
    return e;
  endfunction

  task automatic issue(input logic [3:0] op, input logic [31:0] a, b, lo, hi,
                       input logic sf, cp, n, z, c, v, input string tag);
    @(negedge clk);
    inValid = 1; opSel = op; srcA = a; srcB = b; accLo = lo; accHi = hi;
    setFlags = sf; condPass = cp; nIn = n; zIn = z; cIn = c; vIn = v;
    @(posedge clk);
    #1;
    q.push_back(model(op, a, b, lo, hi, sf, cp, n, z, c, v, tag));
    inValid = 0;
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (q.size() != 0) begin
        exp_t e;
        logic ok;
        e = q.pop_front();
        checks++;
        ok = (outValid === e.vld) && (wrLo === e.wl) && (wrHi === e.wh) && (flagWr === e.fw);
        if (e.vld)
          ok = ok && (resLo === e.lo) && (resHi === e.hi) && (nOut === e.n) &&
               (zOut === e.z) && (cOut === e.c) && (vOut === e.v);
        if (!ok) begin
          fails++;
          $display("FAIL %s: got v%b lo=%h hi=%h wl%b wh%b fw%b nzcv=%b%b%b%b exp v%b lo=%h hi=%h wl%b wh%b fw%b nzcv=%b%b%b%b",
                   e.tag, outValid, resLo, resHi, wrLo, wrHi, flagWr, nOut, zOut, cOut, vOut,
                   e.vld, e.lo, e.hi, e.wl, e.wh, e.fw, e.n, e.z, e.c, e.v);
        end
      end else if (outValid !== 1'b0) begin
        checks++; fails++;
        $display("FAIL R1: got outValid=%b exp 0 on idle cycle", outValid);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R12 reset state
    if ({outValid, resLo, resHi, wrLo, wrHi, flagWr, nOut, zOut, cOut, vOut} !== '0) begin
      fails++;
      $display("FAIL R12: got lo=%h hi=%h v=%b exp all zero", resLo, resHi, outValid);
    end
    @(negedge clk);
    rstN = 1;
    running = 1;

    issue(4'd0, 32'd7, 32'd6, 0, 0, 1, 1, 1, 1, 0, 0, "R2 R7 mul");
    issue(4'd1, 32'hFFFFFFFF, 32'd1, 32'd1, 0, 1, 1, 1, 0, 1, 0, "R2 R7 muladd wraps to zero");
    issue(4'd0, 32'd3, 32'd5, 0, 0, 0, 1, 1, 0, 0, 1, "R9 no flag update");
    issue(4'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, 1, 1, 0, 1, 0, 0, "R3 R8 umul");
    issue(4'd2, 32'h00010000, 32'h00010000, 0, 0, 1, 1, 0, 1, 0, 0, "R8 zero low word only");
    issue(4'd4, 32'hFFFFFFFE, 32'd3, 0, 0, 1, 1, 0, 0, 1, 1, "R3 R8 smul negative");
    issue(4'd3, 32'd2, 32'd1, 32'hFFFFFFFF, 32'd1, 1, 1, 0, 0, 0, 0, "R4 umac carry into high");
    issue(4'd5, 32'hFFFFFFFF, 32'd1, 32'd1, 32'd0, 1, 1, 1, 0, 0, 0, "R4 R8 smac to zero");
    issue(4'd6, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1, 1, 1, 0, 1, 0, "R5 dual addend");
    issue(4'd8, 32'h40000000, 32'd4, 0, 0, 1, 1, 0, 1, 0, 0, "R6 high mul");
    issue(4'd8, 32'd3, 32'h80000000, 0, 0, 0, 1, 0, 0, 0, 0, "R6 high mul no round");
    issue(4'd12, 32'd3, 32'h80000000, 0, 0, 0, 1, 0, 0, 0, 0, "R6 high mul rounded");
    issue(4'd9, 32'd1, 32'd1, 32'd5, 0, 0, 1, 0, 0, 0, 0, "R6 high mac");
    issue(4'd14, 32'd1, 32'h80000000, 32'd0, 0, 0, 1, 0, 0, 0, 0, "R6 high msub rounded");
    issue(4'd10, 32'd7, 32'd9, 32'd100, 0, 0, 1, 0, 0, 0, 0, "R6 high msub");
    issue(4'd7, 32'd7, 32'd9, 0, 0, 1, 1, 0, 0, 0, 0, "R11 unused 7");
    issue(4'd11, 32'd7, 32'd9, 0, 0, 1, 1, 0, 0, 0, 0, "R11 unused 11");
    issue(4'd15, 32'd7, 32'd9, 0, 0, 1, 1, 0, 0, 0, 0, "R11 unused 15");
    issue(4'd0, 32'd7, 32'd9, 0, 0, 1, 0, 0, 0, 0, 0, "R10 cond fail word");
    issue(4'd5, 32'd7, 32'd9, 1, 2, 1, 0, 0, 0, 0, 0, "R10 cond fail long");

    for (int i = 0; i < 60; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 14));
      issue(op, $urandom, $urandom, $urandom, $urandom, 1'($urandom), 1'($urandom_range(0, 5) != 0),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R1 R3 R6 R9 mixed");
    end

    repeat (4) @(posedge clk);  // R1 idle cycles must stay quiet
    @(negedge clk);
    #1;
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1: got %0d pending results exp 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule